// File: doc/BRIEF.md
# Condition-Action Rule Engine

This block is a small autonomous trigger-response engine. It holds a table of sixteen programmable rules. Each rule pairs one condition with one action. Conditions test GPIO input levels, event strobes, the engine's own counters and timers, and a pre-initialization strobe. Actions drive GPIO outputs, issue packet-send requests toward a packet builder, change counters and timers, set initialization state, or request hibernation. No host processor is involved.

A single register write port loads the rule table and the counter and timer values. Each rule fires once, when its condition goes from false to true. Fired rules wait as pending and are dispatched one per cycle, lowest slot first. Packet requests are held until the downstream logic acknowledges them. A coarse timer tick is derived from the clock by a divider parameter.

Top module: `rule_engine`

## Requirements
- R1: Write address map: slot s (0 to 15), word w is at address 4*s+w. Words 0 and 1 are sub-conditions and word 3 is the action. Counter c is at 0x40+c. Timer t is at 0x80+t; writing it loads the value and clears its running and expired flags. A slot fires only on the rising edge of its condition, so a condition that stays true fires the slot once.
- R2: Sub-condition word: bit 31 enable, bits 30:28 kind, bits 27:24 index, bits 15:0 operand. The kinds are 0 GPIO high, 1 GPIO low, 2 event strobe, 3 counter >= operand, 4 timer expired, 5 pre-init strobe. The condition is the AND of all enabled sub-conditions. A slot with none enabled never fires.
- R3: Action word: bits 31:28 opcode, bits 27:24 index, bits 23:0 argument. If several slots fire together, every one of them runs its action. Actions run one per cycle in ascending slot order. A single fired action takes effect at the second rising edge after its trigger is sampled.
- R4: Initialization-only opcodes take effect only if the firing slot's condition contains an enabled pre-init sub-condition; otherwise they are ignored. These opcodes are 1 set role (arg[3:0] to role_o), 2 clear profiles (one-cycle prof_clr_o), 3 set policy (arg[7:0]) and 4 route status.
- R5: Opcode 12 sets gpio_o[index] to arg[0].
- R6: Opcode 9 adds one to counter[index], wrapping modulo 2^32. Opcode 10 loads counter[index] with the zero-extended argument.
- R7: Timers count down one step per tick; a tick occurs every TICK_DIV cycles. When a running timer reaches zero it stops and sets its expired flag. Opcode 11 controls timer[index] through arg[1:0]: 0 start, 1 stop, 2 reload with arg[17:2], 3 reload and start. Start and reload clear the expired flag.
- R8: Opcode 8 raises pkt_req_o with type arg[1:0] and template arg[11:4]. The request and its fields stay stable until pkt_ack_i is sampled high, and no action is dispatched meanwhile.
- R9: A packet action whose token count arg[15:12] exceeds 8 raises no request.
- R10: Opcode 13 raises hib_req_o. It stays high until reset, and no later action is dispatched.
- R11: After reset, every output is zero and all slots are disabled.
- R12: Kind 3 compares counter[index] against the zero-extended operand, so a counter that reaches the threshold fires the slot.
- R13: Route status with arg[0]=1 makes gpio_o[index] follow status_i[index]. Until then, status_i has no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register write address |
| cfg_wdata_i | input | 32 | Register write data |
| gpio_i | input | GPIO_W | GPIO input levels |
| evt_i | input | EVT_W | Event strobes |
| pre_init_i | input | 1 | Pre-initialization strobe |
| status_i | input | GPIO_W | Internal status signals that can be routed to pins |
| pkt_ack_i | input | 1 | Packet request acknowledge |
| gpio_o | output | GPIO_W | GPIO drive bits |
| pkt_req_o | output | 1 | Packet send request |
| pkt_type_o | output | 2 | Packet type (raw, UDP, TCP) |
| pkt_tmpl_o | output | 8 | Packet template index |
| hib_req_o | output | 1 | Hibernate request |
| role_o | output | 4 | Role set at initialization |
| policy_o | output | 8 | Connection policy set at initialization |
| prof_clr_o | output | 1 | One-cycle profile clear pulse |
| ctr_val_o | output | NUM_CTR*CTR_W | Counter values, counter 0 in the low bits |
| tmr_val_o | output | NUM_TMR*TMR_W | Timer values, timer 0 in the low bits |

## Verification
The bench drives each input at a falling edge and samples at a falling edge. A trigger is captured at the first rising edge after it is driven. A single action becomes visible after the second rising edge. Each further slot fired by the same trigger appears one edge later. A rule that tests a counter changed by another action adds two more edges. Ordering checks sample between consecutive dispatch edges, and timer checks wait longer than the worst-case tick alignment.

// File: rtl/rule_engine_pkg.sv
package rule_engine_pkg;

    typedef enum logic [2:0] {
        SK_GPIO_HI = 3'd0,
        SK_GPIO_LO = 3'd1,
        SK_EVENT   = 3'd2,
        SK_CTR_GE  = 3'd3,
        SK_TMR_EXP = 3'd4,
        SK_PREINIT = 3'd5
    } sub_kind_e;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_SET_ROLE   = 4'd1,
        OP_CLR_PROF   = 4'd2,
        OP_SET_POLICY = 4'd3,
        OP_ROUTE_STAT = 4'd4,
        OP_SEND_PKT   = 4'd8,
        OP_CTR_INC    = 4'd9,
        OP_CTR_LOAD   = 4'd10,
        OP_TMR_CTRL   = 4'd11,
        OP_GPIO_SET   = 4'd12,
        OP_HIBERNATE  = 4'd13
    } act_op_e;

    localparam int WORD_W     = 32;
    localparam int MAX_TOKENS = 8;

endpackage

// File: rtl/rule_tick_gen.sv
module rule_tick_gen #(
    parameter int TICK_DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/rule_cond_eval.sv
module rule_cond_eval
    import rule_engine_pkg::*;
#(
    parameter int SUB_N   = 2,
    parameter int GPIO_W  = 8,
    parameter int EVT_W   = 8,
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 32,
    parameter int NUM_TMR = 8
) (
    input  logic [SUB_N-1:0][WORD_W-1:0]   sub_i,
    input  logic [GPIO_W-1:0]              gpio_i,
    input  logic [EVT_W-1:0]               evt_i,
    input  logic                           pre_init_i,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]  ctr_i,
    input  logic [NUM_TMR-1:0]             tmr_exp_i,
    output logic                           cond_o,
    output logic                           init_o
);
    localparam int GI_W = (GPIO_W  > 1) ? $clog2(GPIO_W)  : 1;
    localparam int EI_W = (EVT_W   > 1) ? $clog2(EVT_W)   : 1;
    localparam int CI_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam int TI_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    logic [SUB_N-1:0] hit;

    always_comb begin
        for (int s = 0; s < SUB_N; s++) begin
            case (sub_kind_e'(sub_i[s][30:28]))
                SK_GPIO_HI: hit[s] = gpio_i[sub_i[s][24 +: GI_W]];
                SK_GPIO_LO: hit[s] = !gpio_i[sub_i[s][24 +: GI_W]];
                SK_EVENT:   hit[s] = evt_i[sub_i[s][24 +: EI_W]];
                SK_CTR_GE:  hit[s] = (ctr_i[sub_i[s][24 +: CI_W]] >= CTR_W'(sub_i[s][15:0]));
                SK_TMR_EXP: hit[s] = tmr_exp_i[sub_i[s][24 +: TI_W]];
                SK_PREINIT: hit[s] = pre_init_i;
                default:    hit[s] = 1'b0;
            endcase
        end
    end

    always_comb begin
        logic any_en;
        logic all_ok;
        logic has_pre;
        any_en  = 1'b0;
        all_ok  = 1'b1;
        has_pre = 1'b0;
        for (int s = 0; s < SUB_N; s++) begin
            if (sub_i[s][31]) begin
                any_en = 1'b1;
                all_ok = all_ok & hit[s];
                if (sub_kind_e'(sub_i[s][30:28]) == SK_PREINIT) has_pre = 1'b1;
            end
        end
        cond_o = any_en & all_ok;
        init_o = has_pre;
    end
endmodule

// File: rtl/rule_pick.sv
module rule_pick #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic          en_i,
    output logic [N-1:0]  grant_o,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        grant_o = '0;
        valid_o = 1'b0;
        idx_o   = '0;
        if (en_i) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req_i[i]) begin
                    grant_o    = '0;
                    grant_o[i] = 1'b1;
                    valid_o    = 1'b1;
                    idx_o      = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/rule_engine.sv
module rule_engine
    import rule_engine_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SUB_N     = 2,
    parameter int GPIO_W    = 8,
    parameter int EVT_W     = 8,
    parameter int NUM_CTR   = 8,
    parameter int CTR_W     = 32,
    parameter int NUM_TMR   = 8,
    parameter int TMR_W     = 16,
    parameter int TICK_DIV  = 100_000_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we_i,
    input  logic [7:0]                 cfg_addr_i,
    input  logic [31:0]                cfg_wdata_i,
    input  logic [GPIO_W-1:0]          gpio_i,
    input  logic [EVT_W-1:0]           evt_i,
    input  logic                       pre_init_i,
    input  logic [GPIO_W-1:0]          status_i,
    input  logic                       pkt_ack_i,
    output logic [GPIO_W-1:0]          gpio_o,
    output logic                       pkt_req_o,
    output logic [1:0]                 pkt_type_o,
    output logic [7:0]                 pkt_tmpl_o,
    output logic                       hib_req_o,
    output logic [3:0]                 role_o,
    output logic [7:0]                 policy_o,
    output logic                       prof_clr_o,
    output logic [NUM_CTR*CTR_W-1:0]   ctr_val_o,
    output logic [NUM_TMR*TMR_W-1:0]   tmr_val_o
);
    localparam int SL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int GI_W = (GPIO_W  > 1) ? $clog2(GPIO_W)  : 1;
    localparam int CI_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam int TI_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
    localparam int ARG_W = 24;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][SUB_N-1:0][WORD_W-1:0] sub;
        logic [NUM_SLOTS-1:0][WORD_W-1:0]            act;
        logic [NUM_SLOTS-1:0]                        cond;
        logic [NUM_SLOTS-1:0]                        pend;
        logic [NUM_SLOTS-1:0]                        pend_init;
        logic [NUM_CTR-1:0][CTR_W-1:0]               ctr;
        logic [NUM_TMR-1:0][TMR_W-1:0]               tmr;
        logic [NUM_TMR-1:0]                          run;
        logic [NUM_TMR-1:0]                          expd;
        logic [GPIO_W-1:0]                           gpio;
        logic [GPIO_W-1:0]                           route;
        logic [3:0]                                  role;
        logic [7:0]                                  policy;
        logic                                        prof_clr;
        logic                                        pkt_req;
        logic [1:0]                                  pkt_type;
        logic [7:0]                                  pkt_tmpl;
        logic                                        hib;
    } state_t;

    state_t d, q;

    logic                  tick;
    logic [NUM_SLOTS-1:0]  cond_now;
    logic [NUM_SLOTS-1:0]  init_now;
    logic [NUM_SLOTS-1:0]  grant;
    logic                  disp_valid;
    logic [SL_W-1:0]       disp_idx;
    logic                  disp_en;
    logic [NUM_SLOTS-1:0]  pend_q;

    rule_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        rule_cond_eval #(
            .SUB_N(SUB_N), .GPIO_W(GPIO_W), .EVT_W(EVT_W),
            .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .NUM_TMR(NUM_TMR)
        ) u_eval (
            .sub_i      (q.sub[g]),
            .gpio_i     (gpio_i),
            .evt_i      (evt_i),
            .pre_init_i (pre_init_i),
            .ctr_i      (q.ctr),
            .tmr_exp_i  (q.expd),
            .cond_o     (cond_now[g]),
            .init_o     (init_now[g])
        );
    end

    assign disp_en = !q.hib && !q.pkt_req;
    assign pend_q  = q.pend;

    rule_pick #(.N(NUM_SLOTS), .IW(SL_W)) u_pick (
        .req_i   (q.pend),
        .en_i    (disp_en),
        .grant_o (grant),
        .valid_o (disp_valid),
        .idx_o   (disp_idx)
    );

    always_comb begin
        logic [NUM_SLOTS-1:0] fire;
        logic [WORD_W-1:0]    aw;
        logic [ARG_W-1:0]     arg;
        logic                 init_ok;
        logic [SL_W-1:0]      wslot;
        logic [CI_W-1:0]      ci;
        logic [TI_W-1:0]      ti;
        logic [GI_W-1:0]      gi;

        d          = q;
        d.prof_clr = 1'b0;

        // timer countdown on tick
        for (int t = 0; t < NUM_TMR; t++) begin
            if (tick && q.run[t]) begin
                if (q.tmr[t] <= TMR_W'(1)) begin
                    d.tmr[t]  = '0;
                    d.run[t]  = 1'b0;
                    d.expd[t] = 1'b1;
                end else begin
                    d.tmr[t] = q.tmr[t] - 1'b1;
                end
            end
        end

        // configuration writes
        wslot = cfg_addr_i[2 +: SL_W];
        if (cfg_we_i) begin
            case (cfg_addr_i[7:6])
                2'b00: begin
                    if (cfg_addr_i[1:0] == 2'd3) d.act[wslot] = cfg_wdata_i;
                    for (int s = 0; s < SUB_N; s++) begin
                        if (int'(cfg_addr_i[1:0]) == s) d.sub[wslot][s] = cfg_wdata_i;
                    end
                end
                2'b01: d.ctr[cfg_addr_i[CI_W-1:0]] = CTR_W'(cfg_wdata_i);
                2'b10: begin
                    d.tmr[cfg_addr_i[TI_W-1:0]]  = cfg_wdata_i[TMR_W-1:0];
                    d.run[cfg_addr_i[TI_W-1:0]]  = 1'b0;
                    d.expd[cfg_addr_i[TI_W-1:0]] = 1'b0;
                end
                default: ;
            endcase
        end

        // edge detection and pending latch
        fire   = cond_now & ~q.cond;
        d.cond = cond_now;
        d.pend = (q.pend & ~grant) | fire;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (fire[i]) d.pend_init[i] = init_now[i];
        end

        // packet acknowledge
        if (q.pkt_req && pkt_ack_i) d.pkt_req = 1'b0;

        // dispatch one action
        aw      = q.act[disp_idx];
        arg     = aw[ARG_W-1:0];
        init_ok = q.pend_init[disp_idx];
        ci      = aw[24 +: CI_W];
        ti      = aw[24 +: TI_W];
        gi      = aw[24 +: GI_W];
        if (disp_valid) begin
            case (act_op_e'(aw[31:28]))
                OP_SET_ROLE:   if (init_ok) d.role = arg[3:0];
                OP_CLR_PROF:   if (init_ok) d.prof_clr = 1'b1;
                OP_SET_POLICY: if (init_ok) d.policy = arg[7:0];
                OP_ROUTE_STAT: if (init_ok) d.route[gi] = arg[0];
                OP_SEND_PKT: begin
                    if (int'(arg[15:12]) <= MAX_TOKENS) begin
                        d.pkt_req  = 1'b1;
                        d.pkt_type = arg[1:0];
                        d.pkt_tmpl = arg[11:4];
                    end
                end
                OP_CTR_INC:  d.ctr[ci] = q.ctr[ci] + 1'b1;
                OP_CTR_LOAD: d.ctr[ci] = CTR_W'(arg);
                OP_TMR_CTRL: begin
                    case (arg[1:0])
                        2'd0: begin
                            d.run[ti]  = 1'b1;
                            d.expd[ti] = 1'b0;
                        end
                        2'd1: d.run[ti] = 1'b0;
                        2'd2: begin
                            d.tmr[ti]  = arg[2 +: TMR_W];
                            d.expd[ti] = 1'b0;
                        end
                        default: begin
                            d.tmr[ti]  = arg[2 +: TMR_W];
                            d.run[ti]  = 1'b1;
                            d.expd[ti] = 1'b0;
                        end
                    endcase
                end
                OP_GPIO_SET:  d.gpio[gi] = arg[0];
                OP_HIBERNATE: d.hib = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign gpio_o     = (q.route & status_i) | (~q.route & q.gpio);
    assign pkt_req_o  = q.pkt_req;
    assign pkt_type_o = q.pkt_type;
    assign pkt_tmpl_o = q.pkt_tmpl;
    assign hib_req_o  = q.hib;
    assign role_o     = q.role;
    assign policy_o   = q.policy;
    assign prof_clr_o = q.prof_clr;
    assign ctr_val_o  = q.ctr;
    assign tmr_val_o  = q.tmr;
endmodule

// File: rtl/rule_engine_chk.sv
module rule_engine_chk #(
    parameter int NUM_SLOTS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hib,
    input logic                 pkt_req,
    input logic                 pkt_ack,
    input logic [1:0]           pkt_type,
    input logic [7:0]           pkt_tmpl,
    input logic [NUM_SLOTS-1:0] grant,
    input logic [NUM_SLOTS-1:0] pend
);
    AST_HIB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hib |=> hib); // R10

    AST_HIB_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        hib |-> (grant == '0)); // R10

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R3

    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0); // R3

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((pend & (grant - 1'b1)) == '0)); // R3

    AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && !pkt_ack) |=> (pkt_req && $stable(pkt_type) && $stable(pkt_tmpl))); // R8

    AST_PKT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && pkt_ack) |=> !pkt_req); // R8
endmodule

bind rule_engine rule_engine_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hib      (hib_req_o),
    .pkt_req  (pkt_req_o),
    .pkt_ack  (pkt_ack_i),
    .pkt_type (pkt_type_o),
    .pkt_tmpl (pkt_tmpl_o),
    .grant    (grant),
    .pend     (pend_q)
);

// File: tb/rule_engine_test.sv
module rule_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  gpio_in = '0;
    logic [7:0]  evt = '0;
    logic        pre_init = 1'b0;
    logic [7:0]  status = '0;
    logic        pkt_ack = 1'b0;
    logic [7:0]  gpio_out;
    logic        pkt_req;
    logic [1:0]  pkt_type;
    logic [7:0]  pkt_tmpl;
    logic        hib;
    logic [3:0]  role;
    logic [7:0]  policy;
    logic        prof_clr;
    logic [255:0] ctr_flat;
    logic [127:0] tmr_flat;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rule_engine #(.TICK_DIV(TICK_DIV)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .gpio_i(gpio_in), .evt_i(evt), .pre_init_i(pre_init), .status_i(status),
        .pkt_ack_i(pkt_ack),
        .gpio_o(gpio_out), .pkt_req_o(pkt_req), .pkt_type_o(pkt_type),
        .pkt_tmpl_o(pkt_tmpl), .hib_req_o(hib), .role_o(role), .policy_o(policy),
        .prof_clr_o(prof_clr), .ctr_val_o(ctr_flat), .tmr_val_o(tmr_flat)
    );

    // gpio[15:12], expected gpio_out[4] at bit 8, expected counter 0 at [7:0]
    localparam logic [15:0] VEC [8] = '{
        16'h1100, 16'h2000, 16'h6001, 16'h7101,
        16'h3101, 16'h7102, 16'h2002, 16'h6003
    };

    function automatic logic [31:0] sub(input int kind, input int idx, input int op);
        return {1'b1, 3'(kind), 4'(idx), 8'h00, 16'(op)};
    endfunction

    function automatic logic [31:0] act(input int op, input int idx, input int arg);
        return {4'(op), 4'(idx), 24'(arg)};
    endfunction

    task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, actual, expected);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_evt(input int k);
        @(negedge clk);
        evt[k] = 1'b1;
        @(negedge clk);
        evt[k] = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] ctr(input int c);
        return ctr_flat[c*32 +: 32];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        check("R11 gpio", 32'(gpio_out), 0);
        check("R11 hib", 32'(hib), 0);
        check("R11 pkt", 32'(pkt_req), 0);
        check("R11 role", 32'(role), 0);
        check("R11 ctr0", ctr(0), 0);

        // table rules
        wr(8'd0,  sub(0, 0, 0));           wr(8'd3,  act(12, 4, 1));
        wr(8'd4,  sub(1, 0, 0));           wr(8'd5,  sub(0, 1, 0));
        wr(8'd7,  act(12, 4, 0));
        wr(8'd8,  sub(2 == 2 ? 0 : 0, 2, 0)); wr(8'd11, act(9, 0, 0));
        wr(8'd60, sub(3, 0, 3));           wr(8'd63, act(12, 3, 1));
        // ordering pair
        wr(8'd12, sub(2, 0, 0));           wr(8'd15, act(10, 1, 5));
        wr(8'd16, sub(2, 0, 0));           wr(8'd19, act(9, 1, 0));
        // init-only
        wr(8'd20, sub(5, 0, 0));           wr(8'd23, act(1, 0, 3));
        wr(8'd24, sub(2, 1, 0));           wr(8'd27, act(1, 0, 7));
        wr(8'd28, sub(5, 0, 0));           wr(8'd31, act(4, 5, 1));
        // wrap
        wr(8'd32, sub(2, 2, 0));           wr(8'd35, act(9, 2, 0));
        // timer
        wr(8'd36, sub(2, 3, 0));           wr(8'd39, act(11, 0, 0));
        wr(8'd40, sub(4, 0, 0));           wr(8'd43, act(12, 6, 1));
        // packets
        wr(8'd44, sub(2, 4, 0));           wr(8'd47, act(8, 0, 32'h8051));
        wr(8'd48, sub(2, 5, 0));           wr(8'd51, act(8, 0, 32'h9051));
        // hibernate
        wr(8'd52, sub(2, 6, 0));           wr(8'd55, act(13, 0, 0));
        wr(8'd56, sub(2, 6, 0));           wr(8'd59, act(12, 7, 1));

        check("R2 no spurious fire", 32'(gpio_out), 0);

        // vector table: R1 edge firing, R2 AND, R5 gpio, R6 increment
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            gpio_in[3:0] = VEC[v][15:12];
            repeat (5) @(negedge clk);
            check("R5 R2 gpio4", 32'(gpio_out[4]), 32'(VEC[v][8]));
            check("R1 R6 ctr0", ctr(0), 32'(VEC[v][7:0]));
        end
        repeat (3) @(negedge clk);
        check("R12 counter threshold", 32'(gpio_out[3]), 1);

        // R3 ordering: two slots share event 0
        pulse_evt(0);
        @(negedge clk);
        check("R3 first slot", ctr(1), 5);
        @(negedge clk);
        check("R3 second slot", ctr(1), 6);

        // R4 init-only ignored outside pre-init, R13 routing
        status[5] = 1'b1;
        pulse_evt(1);
        repeat (3) @(negedge clk);
        check("R4 role ignored", 32'(role), 0);
        check("R13 not routed", 32'(gpio_out[5]), 0);
        @(negedge clk); pre_init = 1'b1;
        @(negedge clk); pre_init = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 role set", 32'(role), 3);
        check("R13 routed", 32'(gpio_out[5]), 1);
        status[5] = 1'b0;
        #1;
        check("R13 follows status", 32'(gpio_out[5]), 0);

        // R6 wrap
        wr(8'h42, 32'hFFFF_FFFF);
        pulse_evt(2);
        @(negedge clk);
        check("R6 wrap", ctr(2), 0);

        // R7 timer
        wr(8'h80, 32'd3);
        check("R7 timer load", 32'(tmr_flat[15:0]), 3);
        pulse_evt(3);
        @(negedge clk);
        check("R7 not expired yet", 32'(gpio_out[6]), 0);
        repeat (20) @(negedge clk);
        check("R7 timer zero", 32'(tmr_flat[15:0]), 0);
        check("R7 expiry fires", 32'(gpio_out[6]), 1);

        // R8 packet request
        pulse_evt(4);
        @(negedge clk);
        check("R8 req", 32'(pkt_req), 1);
        check("R8 type", 32'(pkt_type), 1);
        check("R8 tmpl", 32'(pkt_tmpl), 5);
        repeat (5) @(negedge clk);
        check("R8 held", 32'(pkt_req), 1);
        pkt_ack = 1'b1;
        @(negedge clk);
        pkt_ack = 1'b0;
        check("R8 released", 32'(pkt_req), 0);

        // R9 token limit
        pulse_evt(5);
        repeat (4) @(negedge clk);
        check("R9 rejected", 32'(pkt_req), 0);

        // R10 hibernate
        pulse_evt(6);
        @(negedge clk);
        check("R10 hib", 32'(hib), 1);
        repeat (4) @(negedge clk);
        check("R10 later slot blocked", 32'(gpio_out[7]), 0);
        pulse_evt(2);
        repeat (3) @(negedge clk);
        check("R10 no dispatch", ctr(2), 0);
        check("R10 hib held", 32'(hib), 1);

        // R11 reset again
        do_reset();
        check("R11 hib cleared", 32'(hib), 0);
        check("R11 gpio cleared", 32'(gpio_out), 0);
        check("R11 ctr cleared", ctr(1), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule